// File: doc/BRIEF.md
# Auto-Reload Bit-Rate Timer

This block is a 16-bit up-counter that produces the bit-rate tick for a serial port. Software loads a 16-bit reload value into a byte pair, selects the timer as the source for the receive clock, the transmit clock or both, and sets the run bit. The counter then advances once per state time, which is every second input clock. When it steps past all ones it takes the reload value, emits a one-cycle overflow pulse, and a divide-by-16 stage turns every sixteenth pulse into a one-cycle rate tick. The tick period is therefore 32 × (65536 − reload) input clocks.

An overflow in this mode sets no flag. A separate falling-edge detector watches an external pin. When edge sensing is enabled, a high-to-low transition sets a sticky flag that software clears. The edge never touches the count or forces a reload, so the pin can serve as a spare event input. All registers sit behind a synchronous byte-wide write port and a combinational read mux. Software is expected to stop the timer before it touches the count or reload bytes.

Top module: `brt_timer`

## Requirements
- R1: After reset the count, reload value and control register all read 0, and ovf_pulse, rate_tick, rx_tick, tx_tick and ext_flag are 0.
- R2: A write with wr_en high at a clock edge stores wdata into the register at addr: 0 count low byte, 1 count high byte, 2 reload low byte, 3 reload high byte, 4 control. rd_data shows the addressed register combinationally. Control bits are [0] run, [1] receive select, [2] transmit select, [3] edge enable, [4] edge flag, and bits [7:5] read 0. Addresses 5 to 7 read 0.
- R3: The count does not change unless run is 1 and at least one of the two select bits is 1. While inactive, no overflow pulse appears.
- R4: While active, the count rises by one every second clock. It is first incremented on the second clock edge after the edge that wrote the control register.
- R5: On the step after the count reaches 16'hFFFF, the count is loaded with the full 16-bit reload value, and ovf_pulse is high for exactly the one cycle that follows that edge. Overflow never sets any control bit.
- R6: rate_tick is a one-cycle pulse that coincides with every sixteenth ovf_pulse. Consecutive ticks are 32 × (65536 − reload) clocks apart, and consecutive overflow pulses are 2 × (65536 − reload) clocks apart. This includes reload 16'hFFFF, which gives 32 and 2.
- R7: rx_tick equals rate_tick when the receive select bit is 1 and is 0 otherwise. tx_tick behaves the same way with the transmit select bit.
- R8: With the edge enable bit at 1, a high-to-low transition on ext_pin sets the edge flag within three clocks. With the enable bit at 0, or on a rising transition, the flag stays clear.
- R9: An ext_pin falling edge never changes the count and never causes a reload.
- R10: The edge flag stays set until a control write puts 0 in bit 4. Writing 1 to bit 4 never sets it. If an edge arrives in the same cycle as a clearing write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Read data of the addressed register |
| ext_pin | input | 1 | External event pin |
| ovf_pulse | output | 1 | One-cycle pulse per counter rollover |
| rate_tick | output | 1 | One-cycle tick per sixteen rollovers |
| rx_tick | output | 1 | rate_tick gated by the receive select bit |
| tx_tick | output | 1 | rate_tick gated by the transmit select bit |
| ext_flag | output | 1 | Sticky external edge flag |

## Verification
The bench presets the count to 16'hFFFE with a distinctive reload value and starts the timer. A design that reloaded only one byte, or that restarted from zero, shows the wrong count in the cycle after rollover. Tick and overflow spacing are measured for reload 16'hFFFF and for random reloads near the top of the range. This catches a missing state-time prescale, a divide-by-16 stage that is off by one, and a pulse that lasts more than one cycle. The bench applies pin edges while a known count sits in the stopped timer, so a design that reloads on an edge, sets the flag on a rising edge or with sensing disabled, or lets a write of 1 set the flag is exposed through the register reads.

// File: rtl/brt_pkg.sv
package brt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

    localparam int CTL_RUN  = 0;
    localparam int CTL_RXS  = 1;
    localparam int CTL_TXS  = 2;
    localparam int CTL_EXEN = 3;
    localparam int CTL_FLAG = 4;
endpackage

// File: rtl/brt_prescale.sv
module brt_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic step
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] ph_q, ph_d;

    assign step = en && (ph_q == PW'(DIV - 1));

    always_comb begin
        if (!en || step) ph_d = '0;
        else             ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    generate
        if (DIV > 1) begin : g_space
            // R4: steps never fall on adjacent clocks
            p_step_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> !step);
        end
    endgenerate
endmodule

// File: rtl/brt_count16.sv
module brt_count16 #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   reload,
    output logic [2*DATA_W-1:0]   count,
    output logic                  wrap,
    output logic                  ovf
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    assign wrap  = step && (st_q.cnt == TOP);
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = wrap;
        if (step) st_d.cnt = wrap ? reload : st_q.cnt + 1'b1;
        if (wr_lo) st_d.cnt[DATA_W-1:0]     = wdata;
        if (wr_hi) st_d.cnt[CNT_W-1:DATA_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: rollover takes the whole reload value
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.cnt == TOP && !wr_lo && !wr_hi) |=> st_q.cnt == $past(reload));
    // R3: no step and no write leaves the count alone
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_lo && !wr_hi) |=> $stable(st_q.cnt));
    // R5: overflow pulse is one cycle wide
    p_ovf_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> !st_q.ovf);
endmodule

// File: rtl/brt_div16.sv
module brt_div16 #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    output logic tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             tick;
    } div_st_t;

    div_st_t st_q, st_d;

    assign tick = st_q.tick;

    always_comb begin
        st_d      = st_q;
        st_d.tick = wrap && (&st_q.div);
        if (wrap) st_d.div = st_q.div + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: tick never lasts two cycles
    p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);
endmodule

// File: rtl/brt_fall_detect.sv
module brt_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic samp_q, prev_q;

    assign fall = prev_q && !samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            samp_q <= pin;
            prev_q <= samp_q;
        end
    end

    // R8: one detection per falling edge
    p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/brt_timer.sv
module brt_timer
    import brt_pkg::*;
#(
    parameter int STATE_DIV = 2,
    parameter int TICK_DIV_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_pin,
    output logic              ovf_pulse,
    output logic              rate_tick,
    output logic              rx_tick,
    output logic              tx_tick,
    output logic              ext_flag
);
    localparam int CNT_W = 2 * DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             rxs;
        logic             txs;
        logic             exen;
        logic             flag;
    } reg_st_t;

    reg_st_t rg_q, rg_d;

    logic             wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi, wr_ctl;
    logic             active, step, wrap, fall;
    logic [CNT_W-1:0] count;

    assign wr_cnt_lo = wr_en && (addr == A_CNT_LO);
    assign wr_cnt_hi = wr_en && (addr == A_CNT_HI);
    assign wr_rld_lo = wr_en && (addr == A_RLD_LO);
    assign wr_rld_hi = wr_en && (addr == A_RLD_HI);
    assign wr_ctl    = wr_en && (addr == A_CTRL);
    assign active    = rg_q.run && (rg_q.rxs || rg_q.txs);

    brt_prescale #(.DIV(STATE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(active), .step(step)
    );

    brt_count16 #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step),
        .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(wdata),
        .reload(rg_q.reload), .count(count), .wrap(wrap), .ovf(ovf_pulse)
    );

    brt_div16 #(.DIV_W(TICK_DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .tick(rate_tick)
    );

    brt_fall_detect u_edge (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall(fall)
    );

    always_comb begin
        rg_d = rg_q;
        if (wr_rld_lo) rg_d.reload[DATA_W-1:0]     = wdata;
        if (wr_rld_hi) rg_d.reload[CNT_W-1:DATA_W] = wdata;
        if (wr_ctl) begin
            rg_d.run  = wdata[CTL_RUN];
            rg_d.rxs  = wdata[CTL_RXS];
            rg_d.txs  = wdata[CTL_TXS];
            rg_d.exen = wdata[CTL_EXEN];
            rg_d.flag = rg_q.flag && wdata[CTL_FLAG];
        end
        if (fall && rg_q.exen) rg_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            A_CNT_LO: rd_data = count[DATA_W-1:0];
            A_CNT_HI: rd_data = count[CNT_W-1:DATA_W];
            A_RLD_LO: rd_data = rg_q.reload[DATA_W-1:0];
            A_RLD_HI: rd_data = rg_q.reload[CNT_W-1:DATA_W];
            A_CTRL: begin
                rd_data[CTL_RUN]  = rg_q.run;
                rd_data[CTL_RXS]  = rg_q.rxs;
                rd_data[CTL_TXS]  = rg_q.txs;
                rd_data[CTL_EXEN] = rg_q.exen;
                rd_data[CTL_FLAG] = rg_q.flag;
            end
            default: rd_data = '0;
        endcase
    end

    assign rx_tick  = rate_tick && rg_q.rxs;
    assign tx_tick  = rate_tick && rg_q.txs;
    assign ext_flag = rg_q.flag;

    // R10: flag survives everything except a clearing control write
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !(wr_ctl && !wdata[CTL_FLAG])) |=> ext_flag);
    // R7: a select-gated tick needs the shared tick
    p_rx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> rate_tick);
    p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> rate_tick);
    // R6: tick only alongside an overflow pulse
    p_tick_with_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick |-> ovf_pulse);
    // R3: inactive timer yields no overflow next cycle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ovf_pulse);
endmodule

// File: tb/brt_timer_test.sv
module brt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rd_data;
    logic       ext_pin = 1'b1;
    logic       ovf_pulse, rate_tick, rx_tick, tx_tick, ext_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    brt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .ext_pin(ext_pin), .ovf_pulse(ovf_pulse),
        .rate_tick(rate_tick), .rx_tick(rx_tick), .tx_tick(tx_tick),
        .ext_flag(ext_flag)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        c = {hi, lo};
    endtask

    function automatic int ovf_gap(input logic [15:0] r);
        return 2 * (65536 - int'(r));
    endfunction

    function automatic int tick_gap(input logic [15:0] r);
        return 32 * (65536 - int'(r));
    endfunction

    task automatic gap_of(input bit use_tick, output int n);
        int lim;
        lim = 0;
        while ((use_tick ? rate_tick : ovf_pulse) !== 1'b1 && lim < 5000) begin
            @(negedge clk); lim++;
        end
        n = 0;
        do begin
            @(negedge clk); n++;
        end while ((use_tick ? rate_tick : ovf_pulse) !== 1'b1 && n < 5000);
    endtask

    task automatic arm(input logic [15:0] r, input logic [7:0] ctl);
        wr(3'd4, 8'h00);
        wr(3'd2, r[7:0]);
        wr(3'd3, r[15:8]);
        wr(3'd0, r[7:0]);
        wr(3'd1, r[15:8]);
        wr(3'd4, ctl);
    endtask

    initial begin
        logic [7:0]  v;
        logic [15:0] c;
        int          n;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_cnt(c);      check("R1 count", c, 16'h0000);
        rd(3'd2, v);    check("R1 reload lo", v, 0);
        rd(3'd3, v);    check("R1 reload hi", v, 0);
        rd(3'd4, v);    check("R1 control", v, 0);
        check("R1 outputs", {ovf_pulse, rate_tick, rx_tick, tx_tick, ext_flag}, 0);

        // R2 register access
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wr(3'(i), d);
            rd(3'(i), v);
            check("R2 byte readback", v, d);
        end
        wr(3'd4, 8'hFE);
        rd(3'd4, v);    check("R2 control mask and flag write-1", v, 8'h0E);
        rd(3'd5, v);    check("R2 unused addr", v, 0);

        // R3 run without select, select without run
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00); wr(3'd1, 8'h01);
        wr(3'd4, 8'h01);
        repeat (10) @(negedge clk);
        rd_cnt(c);      check("R3 run no select", c, 16'h0100);
        wr(3'd4, 8'h06);
        repeat (10) @(negedge clk);
        rd_cnt(c);      check("R3 select no run", c, 16'h0100);

        // R4 one step per two clocks
        wr(3'd4, 8'h03);
        repeat (1) @(negedge clk);
        rd_cnt(c);      check("R4 first edge no step", c, 16'h0100);
        repeat (9) @(negedge clk);
        rd_cnt(c);      check("R4 ten edges", c, 16'h0105);

        // R5 full reload on rollover, one-cycle pulse, no flag
        wr(3'd4, 8'h00);
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
        wr(3'd2, 8'h34); wr(3'd3, 8'h12);
        wr(3'd4, 8'h03);
        repeat (3) @(negedge clk);
        check("R5 no early pulse", ovf_pulse, 0);
        @(negedge clk);
        check("R5 pulse", ovf_pulse, 1);
        rd_cnt(c);      check("R5 reloaded", c, 16'h1234);
        rd(3'd4, v);    check("R5 no flag from overflow", v, 8'h03);
        @(negedge clk);
        check("R5 pulse width", ovf_pulse, 0);

        // R6 boundary reload FFFF
        arm(16'hFFFF, 8'h07);
        gap_of(1'b0, n); check("R6 ovf gap FFFF", n, ovf_gap(16'hFFFF));
        gap_of(1'b1, n); check("R6 tick gap FFFF", n, tick_gap(16'hFFFF));
        @(negedge clk);
        check("R6 tick width", rate_tick, 0);

        // R6/R7 random reloads and selects
        for (int k = 0; k < 6; k++) begin
            logic [15:0] r;
            logic [1:0]  sel;
            r   = 16'hFFFF - 16'($urandom % 48);
            sel = 2'(1 + ($urandom % 3));
            arm(r, {5'd0, sel, 1'b1});
            gap_of(1'b0, n); check("R6 ovf gap", n, ovf_gap(r));
            gap_of(1'b1, n); check("R6 tick gap", n, tick_gap(r));
            check("R7 rx gate", rx_tick, sel[0]);
            check("R7 tx gate", tx_tick, sel[1]);
        end

        // R8/R9/R10 edge flag
        wr(3'd4, 8'h00);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd0, 8'h5A); wr(3'd1, 8'hA5);
        wr(3'd4, 8'h08);
        ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd4, v);    check("R8 fall sets flag", v, 8'h18);
        check("R8 flag port", ext_flag, 1);
        rd_cnt(c);      check("R9 count untouched", c, 16'hA55A);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd4, v);    check("R10 sticky across rise", v, 8'h18);
        wr(3'd4, 8'h18);
        rd(3'd4, v);    check("R10 write 1 keeps", v, 8'h18);
        wr(3'd4, 8'h08);
        rd(3'd4, v);    check("R10 cleared", v, 8'h08);
        wr(3'd4, 8'h00);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd4, v);    check("R8 disabled no flag", v, 8'h00);
        wr(3'd4, 8'h08);
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd4, v);    check("R8 rise no flag", v, 8'h08);
        rd_cnt(c);      check("R9 count still untouched", c, 16'hA55A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule